// File: doc/BRIEF.md
# Tone Transceiver Host Register Interface

This block is the host-facing register file of a dual-tone transceiver. A processor reaches it over a 4-bit bus with an active-low chip select, one register-select line, a read/write line and a bus strobe. Through it the processor loads the digit code to transmit, reads the last digit the receiver validated, sets two control registers that share a single address, and polls a status register. The tone generator, the tone detector and the call-progress comparator are outside the block. They connect through plain strobe, flag and level ports.

The strobe is asynchronous to the block clock and passes through a two-stage synchronizer. An access is taken on the falling edge of the synchronized strobe. Read data is driven only while the chip is selected, the line reads high and the strobe is high. A status read clears the sticky flags on the same falling edge, after the host has latched the value. The block also drives the active-low interrupt pin. That pin carries one of three things: the interrupt request, the validated-tone level in test mode, or the comparator square wave in call-progress mode.

Top module: `tone_host_regs`

## Requirements
- R1: Register decode. Select 0 with write loads `tx_code` and gives one single-cycle `tx_load` pulse. Select 0 with read returns the receive code latched at the last `rx_latch`. Select 1 with write goes to control. Select 1 with read returns status, with bit 0 = interrupt occurred, bit 1 = transmit empty, bit 2 = receive full, and bit 3 = no validated tone present (the inverse of `steer_present`).
- R2: While `bus_cs_n` is high, accesses change nothing and `bus_data_oe` stays low. `bus_data_oe` is also low while the strobe is low.
- R3: Control A holds bit 0 tone enable (`tone_en`), bit 1 call-progress mode (`cp_mode`), bit 2 interrupt enable and bit 3 redirect.
- R4: A control write with bit 3 set sends only the next control write to control B. Every later control write goes to control A. Control B is left unchanged by writes to A.
- R5: Control B holds bit 0 burst disable (`burst_off`, 0 = burst mode), bit 1 test (`test_mode`), bit 2 single tone (`single_tone`) and bit 3 column select (`column_sel`).
- R6: A status read clears status bits 0 to 2. Bit 3 follows `steer_present` live.
- R7: With interrupts enabled and not in call-progress mode, `irq_n` goes low after `rx_latch` or after a burst-mode `tx_ready`. It returns high after a status read.
- R8: In test mode outside call-progress mode, `irq_n` is low exactly while `steer_present` is high.
- R9: In call-progress mode with interrupts enabled, `irq_n` follows `cp_square`. In call-progress mode, `rx_latch` neither sets receive full nor loads the receive code.
- R10: While burst mode is disabled, status bit 1 is held clear and `tx_ready` raises no interrupt.
- R11: Reset clears both control registers and all status flags, and `irq_n` is high.
- R12: A write takes effect only after the strobe falls, and not while the strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_sel | input | 1 | Register select |
| bus_rd_wr | input | 1 | 1 = read, 0 = write |
| bus_strobe | input | 1 | Bus strobe, asynchronous |
| bus_data_in | input | 4 | Write data |
| bus_data_out | output | 4 | Read data |
| bus_data_oe | output | 1 | Read data drive enable |
| tx_code | output | 4 | Digit code to transmit |
| tx_load | output | 1 | One-cycle pulse on a transmit write |
| tx_ready | input | 1 | Pulse from the burst timer when its pause ends |
| rx_code | input | 4 | Code from the detector |
| rx_latch | input | 1 | Pulse when the detector validates a tone |
| steer_present | input | 1 | High while a validated tone is present |
| cp_square | input | 1 | Call-progress comparator output |
| tone_en | output | 1 | Tone output enable |
| cp_mode | output | 1 | Call-progress mode |
| burst_off | output | 1 | Burst mode disabled |
| test_mode | output | 1 | Test mode |
| single_tone | output | 1 | Single-tone generation |
| column_sel | output | 1 | Column tone select in single-tone mode |
| irq_n | output | 1 | Interrupt / call-progress pin, active low |

## Verification
The bench focuses on the shared control address. A redirect that lasts past one write would send later writes to control B and corrupt test or burst settings. A redirect that is ignored would let control A writes leak into B. It checks that a status read clears only the sticky flags, so a design that also cleared the live steering bit, or that never released `irq_n`, shows up. It drives `tx_ready` with burst disabled and `rx_latch` in call-progress mode, where a careless design would set flags. It also writes with chip select high and checks control values while the strobe is still high, which catches decode that ignores select or acts on the rising edge.

// File: rtl/tone_host_regs.sv
module tone_host_regs #(
  parameter int DW = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_sel,
  input  logic          bus_rd_wr,
  input  logic          bus_strobe,
  input  logic [DW-1:0] bus_data_in,
  output logic [DW-1:0] bus_data_out,
  output logic          bus_data_oe,
  output logic [DW-1:0] tx_code,
  output logic          tx_load,
  input  logic          tx_ready,
  input  logic [DW-1:0] rx_code,
  input  logic          rx_latch,
  input  logic          steer_present,
  input  logic          cp_square,
  output logic          tone_en,
  output logic          cp_mode,
  output logic          burst_off,
  output logic          test_mode,
  output logic          single_tone,
  output logic          column_sel,
  output logic          irq_n
);

  logic [SYNC:0]   stb_q;
  logic [DW-1:0]   ctl_a, ctl_b, rx_q;
  logic            to_b, rx_full, tx_empty, irq_flag;

  wire fall    = stb_q[SYNC] & ~stb_q[SYNC-1];
  wire acc     = fall & ~bus_cs_n;
  wire tx_wr   = acc & ~bus_sel & ~bus_rd_wr;
  wire ctl_wr  = acc &  bus_sel & ~bus_rd_wr;
  wire stat_rd = acc &  bus_sel &  bus_rd_wr;
  wire irq_en  = ctl_a[2];
  wire rx_set  = rx_latch & ~ctl_a[1];
  wire tx_set  = tx_ready & ~ctl_b[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stb_q <= '0;
    else        stb_q <= {stb_q[SYNC-1:0], bus_strobe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a <= '0; ctl_b <= '0; to_b <= 1'b0;
      tx_code <= '0; tx_load <= 1'b0; rx_q <= '0;
    end else begin
      tx_load <= tx_wr;
      if (tx_wr) tx_code <= bus_data_in;
      if (rx_set) rx_q <= rx_code;
      if (ctl_wr) begin
        if (to_b) begin
          ctl_b <= bus_data_in;
          to_b  <= 1'b0;
        end else begin
          ctl_a <= bus_data_in;
          to_b  <= bus_data_in[3];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0; tx_empty <= 1'b0; irq_flag <= 1'b0;
    end else begin
      rx_full  <= rx_set | (rx_full & ~stat_rd);
      tx_empty <= ~ctl_b[0] & (tx_set | (tx_empty & ~stat_rd));
      irq_flag <= rx_set | tx_set | (irq_flag & ~stat_rd);
    end
  end

  wire [DW-1:0] status = {~steer_present, rx_full, tx_empty, irq_flag};

  assign bus_data_oe  = ~bus_cs_n & bus_strobe & bus_rd_wr;
  assign bus_data_out = bus_data_oe ? (bus_sel ? status : rx_q) : '0;

  assign tone_en     = ctl_a[0];
  assign cp_mode     = ctl_a[1];
  assign burst_off   = ctl_b[0];
  assign test_mode   = ctl_b[1];
  assign single_tone = ctl_b[2];
  assign column_sel  = ctl_b[3];

  always_comb begin
    if (cp_mode)        irq_n = irq_en ? cp_square : 1'b1;
    else if (test_mode) irq_n = ~steer_present;
    else if (irq_en)    irq_n = ~irq_flag;
    else                irq_n = 1'b1;
  end

  assert_redirect_oneshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && to_b) |=> (!to_b && $stable(ctl_a)));
  assert_b_untouched_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_wr || !to_b) |=> $stable(ctl_b));
  assert_status_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !rx_latch && !tx_ready) |=> (!rx_full && !tx_empty && !irq_flag));
  assert_no_tx_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b[0] |=> !tx_empty);
  assert_rx_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_latch || ctl_a[1]) |=> $stable(rx_q));
  assert_cs_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |=> ($stable(ctl_a) && !tx_load));

endmodule

// File: tb/tone_host_regs_bench.sv
module tone_host_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic bus_cs_n = 1, bus_sel = 0, bus_rd_wr = 1, bus_strobe = 0;
  logic [3:0] bus_data_in = 0, rx_code = 0;
  logic tx_ready = 0, rx_latch = 0, steer_present = 0, cp_square = 0;
  logic [3:0] bus_data_out, tx_code;
  logic bus_data_oe, tx_load, tone_en, cp_mode, burst_off, test_mode, single_tone, column_sel, irq_n;

  int checks = 0, fails = 0, loads = 0;
  logic [3:0] exp_q[$];
  string req_q[$];
  logic [3:0] got_rd;
  event rd_ev;

  tone_host_regs u_tone_host_regs (.*);

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) if (tx_load) loads++;

  initial begin
    #(CLK_PERIOD*20000);
    checks++; fails++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always begin
    @(rd_ev);
    checks++;
    if (exp_q.size() == 0) begin
      fails++; $display("FAIL scoreboard: read with no expected item got %h expected none", got_rd);
    end else begin
      automatic logic [3:0] e = exp_q.pop_front();
      automatic string r = req_q.pop_front();
      if (got_rd !== e) begin
        fails++; $display("FAIL %s: read got %h expected %h", r, got_rd, e);
      end
    end
  end

  task automatic chk(input logic [3:0] got, input logic [3:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++; $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [3:0] d, input logic csn = 0);
    @(negedge clk);
    bus_cs_n = csn; bus_sel = sel; bus_rd_wr = 0; bus_data_in = d; bus_strobe = 1;
    repeat (4) @(negedge clk);
    bus_strobe = 0;
    repeat (4) @(negedge clk);
    bus_cs_n = 1;
  endtask

  task automatic bus_rd(input logic sel, input logic [3:0] e, input string req);
    exp_q.push_back(e); req_q.push_back(req);
    @(negedge clk);
    bus_cs_n = 0; bus_sel = sel; bus_rd_wr = 1; bus_strobe = 1;
    repeat (4) @(negedge clk);
    got_rd = bus_data_out;
    ->rd_ev;
    bus_strobe = 0;
    @(negedge clk);
    chk({3'b0, bus_data_oe}, 4'h0, "R2 oe low with strobe low");
    repeat (3) @(negedge clk);
    bus_cs_n = 1;
  endtask

  task automatic pulse_rx(input logic [3:0] c);
    @(negedge clk); rx_code = c; rx_latch = 1;
    @(negedge clk); rx_latch = 0;
    @(negedge clk);
  endtask

  task automatic pulse_tx;
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk({tone_en, cp_mode, burst_off, test_mode}, 4'h0, "R11 control A/B cleared");
    chk({3'b0, irq_n}, 4'h1, "R11 irq_n high");
    bus_rd(1, 4'b1000, "R11 status after reset");
    bus_rd(0, 4'h0, "R11 rx code after reset");

    // R3 and R12: write control A, check during strobe high
    @(negedge clk);
    bus_cs_n = 0; bus_sel = 1; bus_rd_wr = 0; bus_data_in = 4'b0101; bus_strobe = 1;
    repeat (4) @(negedge clk);
    chk({3'b0, tone_en}, 4'h0, "R12 no effect while strobe high");
    bus_strobe = 0;
    repeat (4) @(negedge clk);
    bus_cs_n = 1;
    chk({2'b0, tone_en, cp_mode}, 4'b0010, "R3 tone enable set, DTMF mode");

    // R4/R5 redirect then control B
    bus_wr(1, 4'b1000);
    chk({3'b0, tone_en}, 4'h0, "R3 control A rewritten");
    bus_wr(1, 4'b0110);
    chk({column_sel, single_tone, test_mode, burst_off}, 4'b0110, "R5 control B fields");
    bus_wr(1, 4'b0001);
    chk({column_sel, single_tone, test_mode, burst_off}, 4'b0110, "R4 control B unchanged after redirect used");
    chk({3'b0, tone_en}, 4'h1, "R4 later write goes to A");

    // R8 test mode
    steer_present = 1; @(negedge clk);
    chk({3'b0, irq_n}, 4'h0, "R8 irq_n low with tone present");
    steer_present = 0; @(negedge clk);
    chk({3'b0, irq_n}, 4'h1, "R8 irq_n high with tone absent");

    bus_wr(1, 4'b1000);
    bus_wr(1, 4'b0000);
    bus_wr(1, 4'b0100);
    chk({column_sel, single_tone, test_mode, burst_off}, 4'h0, "R5 control B cleared");

    // R7 receive interrupt, R6 clear on read, R1 rx read
    steer_present = 1;
    pulse_rx(4'h9);
    chk({3'b0, irq_n}, 4'h0, "R7 irq on receive");
    bus_rd(1, 4'b0101, "R6 status with rx full");
    chk({3'b0, irq_n}, 4'h1, "R7 irq released by status read");
    bus_rd(1, 4'b0000, "R6 flags cleared, steering live");
    bus_rd(0, 4'h9, "R1 rx code read");
    steer_present = 0;

    // R1 transmit write, R7 burst ready interrupt
    bus_wr(0, 4'h7);
    chk(tx_code, 4'h7, "R1 tx code");
    chk(4'(loads), 4'h1, "R1 one tx_load pulse");
    pulse_tx();
    chk({3'b0, irq_n}, 4'h0, "R7 irq on burst ready");
    bus_rd(1, 4'b1011, "R1 status bit order with tx empty");
    chk({3'b0, irq_n}, 4'h1, "R7 irq released");

    // R10 burst disabled
    bus_wr(1, 4'b1100);
    bus_wr(1, 4'b0001);
    chk({3'b0, burst_off}, 4'h1, "R5 burst disabled");
    pulse_tx();
    chk({3'b0, irq_n}, 4'h1, "R10 no irq from tx_ready");
    bus_rd(1, 4'b1000, "R10 tx empty held clear");

    // R2 chip select high
    bus_wr(1, 4'b0011, 1'b1);
    chk({2'b0, tone_en, cp_mode}, 4'b0000, "R2 write ignored with cs high");
    bus_wr(0, 4'h3, 1'b1);
    chk(tx_code, 4'h7, "R2 tx write ignored with cs high");
    @(negedge clk);
    bus_cs_n = 1; bus_rd_wr = 1; bus_strobe = 1;
    repeat (2) @(negedge clk);
    chk({3'b0, bus_data_oe}, 4'h0, "R2 oe low with cs high");
    bus_strobe = 0;
    repeat (4) @(negedge clk);

    // R9 call progress
    bus_wr(1, 4'b0110);
    cp_square = 1; @(negedge clk);
    chk({3'b0, irq_n}, 4'h1, "R9 irq follows square high");
    cp_square = 0; @(negedge clk);
    chk({3'b0, irq_n}, 4'h0, "R9 irq follows square low");
    pulse_rx(4'h2);
    bus_rd(1, 4'b1000, "R9 rx_latch ignored in CP mode");
    bus_rd(0, 4'h9, "R9 rx code kept in CP mode");

    // R11 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk({tone_en, cp_mode, burst_off, test_mode}, 4'h0, "R11 controls cleared by reset");
    chk({3'b0, irq_n}, 4'h1, "R11 irq_n high after reset");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule